// File: doc/BRIEF.md
# Timer Interrupt Status and Routing

This block sits between a bank of event timers and the chip's interrupt fabric. Each timer hands it a one-cycle fire pulse together with its static configuration: enable, trigger type (level or edge), a route field that selects one interrupt line, and a message-delivery enable with a 64-bit message word. The block keeps one status bit per timer, cleared by software writing ones, and turns fire events into held level interrupts, one-cycle edge pulses or memory-write requests.

A global enable gates all delivery without losing recorded status. When the global enable returns, pending level interrupts show up again. A legacy replacement mode steals lines 0 and 8 for timers 0 and 1. While that mode is on, the two legacy inputs (a periodic-timer input and a real-time-clock input) are blocked from those lines. A separate output tells the legacy periodic timer whether it may run. The real-time-clock level is tracked at all times, so line 8 shows its current level as soon as legacy mode ends.

Message requests leave through a valid/ready port. When several timers request in the same cycle, the requests queue up and are sent one after another, lowest timer index first.

Top module: `tirq_router`

## Requirements
- R1: Line selection. With `legacy_mode` high, timer 0 drives line 0 and timer 1 drives line 8, whatever their route fields hold. Every other timer, and timers 0 and 1 when legacy mode is low, drives the line whose number is its route field (`tmr_route` bits [i*RW +: RW]).
- R2: A fire of a level-type timer (`tmr_level`=1) sets that timer's status bit one clock later, even when its enable or the global enable is low. A fire of an edge-type timer leaves the status bit at 0.
- R3: A level-type timer holds its line high while all four of these are true: its status bit is 1, its `tmr_en` is 1, `glb_en` is 1 and `tmr_msg_en` is 0. When an enable goes low the line drops, and it rises again as soon as the enables return while the status bit is still 1.
- R4: A fire of an enabled edge-type timer (global enable high, message enable low) raises its line for exactly the one clock cycle after the fire.
- R5: A cycle with `sts_wr`=1 clears every status bit whose `sts_wdata` bit is 1, and the matching level line falls. Bits written with 0 are unchanged. A fire in the same cycle takes priority and sets the bit.
- R6: While a timer is configured as edge type, its status bit is 0. Switching a timer from level to edge therefore clears a pending bit and lowers its line.
- R7: While `glb_en` is 0, no timer drives any line and status bits keep their values.
- R8: `pit_enable_out` is 1 out of reset. From then on it equals the inverse of `legacy_mode` as sampled at the previous clock edge.
- R9: When legacy mode is low, line 0 shows `pit_in` and line 8 shows `rtc_in`, each delayed by one clock. When legacy mode is high, neither input reaches a line. The `rtc_in` level keeps being sampled throughout, so line 8 reflects it in the first cycle after legacy mode ends.
- R10: A fire of a timer with `tmr_msg_en`, `tmr_en` and `glb_en` all high makes a message request one clock later. Its address is bits [63:32] of that timer's message word and its data is bits [31:0]. The fire drives no interrupt line.
- R11: `msg_valid`, `msg_addr` and `msg_data` stay unchanged until a cycle in which `msg_ready` is high. Requests made in the same cycle are all delivered, lowest timer index first.
- R12: After reset: all status bits are 0, all lines are 0, `msg_valid` is 0 and `pit_enable_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fire | input | NUM_TMR | One-cycle fire pulse per timer |
| tmr_en | input | NUM_TMR | Per-timer interrupt enable |
| tmr_level | input | NUM_TMR | Per-timer trigger type, 1 = level, 0 = edge |
| tmr_msg_en | input | NUM_TMR | Per-timer message delivery enable |
| tmr_route | input | NUM_TMR*RW | Per-timer line number, RW bits each |
| tmr_msg_word | input | NUM_TMR*64 | Per-timer message word, address high, data low |
| glb_en | input | 1 | Global delivery enable |
| legacy_mode | input | 1 | Legacy replacement routing on |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | NUM_TMR | Write-one-to-clear mask |
| pit_in | input | 1 | Legacy periodic-timer interrupt input |
| rtc_in | input | 1 | Legacy real-time-clock interrupt input |
| msg_ready | input | 1 | Message sink ready |
| irq_line | output | NUM_LINES | Interrupt lines |
| status | output | NUM_TMR | Interrupt status bits |
| pit_enable_out | output | 1 | Legacy periodic-timer run enable |
| msg_valid | output | 1 | Message request valid |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The bench keeps a behavioural model and compares every output against it on every clock. The stimulus runs through several distinct input patterns:

- A level timer fires while disabled, then the timer enable and the global enable are toggled. This shows that recording an event and delivering it are separate steps.
- Write-one-to-clear is tried with a zero mask, with a one mask, and in the same cycle as a fire. This shows the clear cannot touch other bits and that the fire wins.
- An edge-type fire and a level-to-edge switch separate the pulse behaviour from the held-level behaviour.
- The legacy inputs are toggled before, during and after legacy mode. Timers 0 and 1 are fired with route fields that point elsewhere. Three simultaneous message fires meet a stalled sink. Together these expose routing overrides, lost levels, lost requests and the delivery order.

// File: rtl/tirq_pkg.sv
// Package: shared constants and types of the timer interrupt router.
// Assumes lines 0 and 8 exist, so NUM_LINES must be at least 9.
package tirq_pkg;
    localparam int LEG_LINE_A = 0;   // line taken by timer 0 in legacy mode
    localparam int LEG_LINE_B = 8;   // line taken by timer 1 in legacy mode
    localparam int MSG_HALF   = 32;  // width of message address and of data
    localparam int MSG_W      = 2 * MSG_HALF;

    typedef struct packed {
        logic [MSG_HALF-1:0] addr;
        logic [MSG_HALF-1:0] data;
    } msg_word_t;
endpackage

// File: rtl/tirq_status.sv
// Module: per-timer interrupt status and line drive.
// Keeps one write-one-to-clear status bit per timer and a one-cycle edge
// marker. It produces the drive request each timer presents to the line map.
// Assumes fire is a one-cycle pulse and the configuration inputs are static
// around a fire.
module tirq_status #(
    parameter int NUM_TMR = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_TMR-1:0] fire,
    input  logic [NUM_TMR-1:0] tmr_en,
    input  logic [NUM_TMR-1:0] tmr_level,
    input  logic [NUM_TMR-1:0] tmr_msg_en,
    input  logic               glb_en,
    input  logic               sts_wr,
    input  logic [NUM_TMR-1:0] sts_wdata,
    output logic [NUM_TMR-1:0] status,
    output logic [NUM_TMR-1:0] drive
);
    logic [NUM_TMR-1:0] sts_q;
    logic [NUM_TMR-1:0] edge_q;

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
        logic clr_req;
        logic deliver_ok;

        // Clear request from software for this timer.
        assign clr_req    = sts_wr & sts_wdata[i];
        // Delivery permission on a line: both enables on, message path off.
        assign deliver_ok = tmr_en[i] & glb_en & ~tmr_msg_en[i];

        // Status bit: a fire wins, edge type forces zero, a write of 1 clears.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sts_q[i] <= 1'b0;
            end else if (fire[i]) begin
                sts_q[i] <= tmr_level[i];
            end else begin
                sts_q[i] <= sts_q[i] & tmr_level[i] & ~clr_req;
            end
        end

        // Edge marker: high for the one cycle after an edge-type fire.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                edge_q[i] <= 1'b0;
            end else begin
                edge_q[i] <= fire[i] & ~tmr_level[i];
            end
        end

        // Line drive: held level or one-cycle pulse, both gated by delivery.
        assign drive[i] = deliver_ok & (tmr_level[i] ? sts_q[i] : edge_q[i]);
    end

    assign status = sts_q;
endmodule

// File: rtl/tirq_line_map.sv
// Module: routes timer drive requests onto interrupt lines.
// Applies the legacy override for timers 0 and 1, and passes the two
// registered legacy inputs through when legacy mode is off. The real-time-
// clock input is sampled every cycle, whatever the mode.
module tirq_line_map #(
    parameter int NUM_TMR   = 4,
    parameter int NUM_LINES = 16,
    parameter int RW        = $clog2(NUM_LINES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_TMR-1:0]     drive,
    input  logic [NUM_TMR*RW-1:0]  tmr_route,
    input  logic                   legacy_mode,
    input  logic                   pit_in,
    input  logic                   rtc_in,
    output logic [NUM_LINES-1:0]   irq_line,
    output logic                   pit_enable_out
);
    import tirq_pkg::*;

    localparam logic [RW-1:0] LINE_A = RW'(LEG_LINE_A);
    localparam logic [RW-1:0] LINE_B = RW'(LEG_LINE_B);

    logic                 pit_q;
    logic                 rtc_q;
    logic                 pit_en_q;
    logic [RW-1:0]        dest;
    logic [NUM_LINES-1:0] line_c;

    // Sample the legacy inputs and the run-enable for the legacy timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pit_q    <= 1'b0;
            rtc_q    <= 1'b0;
            pit_en_q <= 1'b1;
        end else begin
            pit_q    <= pit_in;
            rtc_q    <= rtc_in;
            pit_en_q <= ~legacy_mode;
        end
    end

    // OR every timer's drive into its selected line, then add pass-through.
    always_comb begin
        line_c = '0;
        dest   = '0;
        for (int i = 0; i < NUM_TMR; i++) begin
            dest = tmr_route[i*RW +: RW];
            if (legacy_mode && i == 0) begin
                dest = LINE_A;
            end else if (legacy_mode && i == 1) begin
                dest = LINE_B;
            end
            if (int'(dest) < NUM_LINES) begin
                line_c[dest] = line_c[dest] | drive[i];
            end
        end
        if (!legacy_mode) begin
            line_c[LEG_LINE_A] = line_c[LEG_LINE_A] | pit_q;
            line_c[LEG_LINE_B] = line_c[LEG_LINE_B] | rtc_q;
        end
    end

    assign irq_line       = line_c;
    assign pit_enable_out = pit_en_q;
endmodule

// File: rtl/tirq_msg_arb.sv
// Module: queues message-write requests and presents them one at a time.
// Keeps a pending bit per timer. When the output slot is empty or being
// accepted, it loads the lowest pending index. Assumes each timer's message
// word is stable from its fire until its request is loaded.
module tirq_msg_arb #(
    parameter int NUM_TMR = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_TMR-1:0]           req,
    input  logic [NUM_TMR*tirq_pkg::MSG_W-1:0] words,
    input  logic                         msg_ready,
    output logic                         msg_valid,
    output logic [tirq_pkg::MSG_HALF-1:0] msg_addr,
    output logic [tirq_pkg::MSG_HALF-1:0] msg_data
);
    import tirq_pkg::*;

    localparam int IW = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1;

    logic [NUM_TMR-1:0] pend_q;
    logic [NUM_TMR-1:0] pend_all;
    logic [NUM_TMR-1:0] grant;
    logic [IW-1:0]      pick;
    logic               slot_free;
    logic               valid_q;
    msg_word_t          word_q;

    // Choose the lowest pending index whenever the slot can take a new one.
    always_comb begin
        pend_all  = pend_q | req;
        slot_free = ~valid_q | msg_ready;
        grant     = '0;
        pick      = '0;
        if (slot_free) begin
            for (int i = NUM_TMR - 1; i >= 0; i--) begin
                if (pend_all[i]) begin
                    pick = IW'(i);
                end
            end
            if (|pend_all) begin
                grant[pick] = 1'b1;
            end
        end
    end

    // Pending set, and output slot load or drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= '0;
            valid_q <= 1'b0;
            word_q  <= '0;
        end else begin
            pend_q <= pend_all & ~grant;
            if (slot_free) begin
                valid_q <= |grant;
                if (|grant) begin
                    word_q <= words[pick*MSG_W +: MSG_W];
                end
            end
        end
    end

    assign msg_valid = valid_q;
    assign msg_addr  = word_q.addr;
    assign msg_data  = word_q.data;
endmodule

// File: rtl/tirq_router.sv
// Module: top of the timer interrupt status and routing block.
// Joins status keeping, line routing and message queueing. All config
// inputs are static levels owned by the timer bank. Assumes NUM_LINES >= 9
// and that route fields name existing lines.
module tirq_router #(
    parameter int NUM_TMR   = 4,
    parameter int NUM_LINES = 16,
    parameter int RW        = $clog2(NUM_LINES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_TMR-1:0]       fire,
    input  logic [NUM_TMR-1:0]       tmr_en,
    input  logic [NUM_TMR-1:0]       tmr_level,
    input  logic [NUM_TMR-1:0]       tmr_msg_en,
    input  logic [NUM_TMR*RW-1:0]    tmr_route,
    input  logic [NUM_TMR*64-1:0]    tmr_msg_word,
    input  logic                     glb_en,
    input  logic                     legacy_mode,
    input  logic                     sts_wr,
    input  logic [NUM_TMR-1:0]       sts_wdata,
    input  logic                     pit_in,
    input  logic                     rtc_in,
    input  logic                     msg_ready,
    output logic [NUM_LINES-1:0]     irq_line,
    output logic [NUM_TMR-1:0]       status,
    output logic                     pit_enable_out,
    output logic                     msg_valid,
    output logic [31:0]              msg_addr,
    output logic [31:0]              msg_data
);
    logic [NUM_TMR-1:0] drive;
    logic [NUM_TMR-1:0] msg_req;

    // Message requests: message path chosen and both enables on.
    assign msg_req = fire & tmr_msg_en & tmr_en & {NUM_TMR{glb_en}};

    tirq_status #(.NUM_TMR(NUM_TMR)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (fire),
        .tmr_en     (tmr_en),
        .tmr_level  (tmr_level),
        .tmr_msg_en (tmr_msg_en),
        .glb_en     (glb_en),
        .sts_wr     (sts_wr),
        .sts_wdata  (sts_wdata),
        .status     (status),
        .drive      (drive)
    );

    tirq_line_map #(.NUM_TMR(NUM_TMR), .NUM_LINES(NUM_LINES), .RW(RW)) u_map (
        .clk            (clk),
        .rst_n          (rst_n),
        .drive          (drive),
        .tmr_route      (tmr_route),
        .legacy_mode    (legacy_mode),
        .pit_in         (pit_in),
        .rtc_in         (rtc_in),
        .irq_line       (irq_line),
        .pit_enable_out (pit_enable_out)
    );

    tirq_msg_arb #(.NUM_TMR(NUM_TMR)) u_msg (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (msg_req),
        .words     (tmr_msg_word),
        .msg_ready (msg_ready),
        .msg_valid (msg_valid),
        .msg_addr  (msg_addr),
        .msg_data  (msg_data)
    );
endmodule

// File: rtl/tirq_router_chk.sv
// Module: property checker for tirq_router, attached by bind below.
// Observes ports only; holds no state of its own.
module tirq_router_chk #(
    parameter int NUM_TMR   = 4,
    parameter int NUM_LINES = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_TMR-1:0]   fire,
    input logic [NUM_TMR-1:0]   tmr_level,
    input logic                 glb_en,
    input logic                 legacy_mode,
    input logic                 sts_wr,
    input logic [NUM_TMR-1:0]   sts_wdata,
    input logic                 msg_ready,
    input logic [NUM_LINES-1:0] irq_line,
    input logic [NUM_TMR-1:0]   status,
    input logic                 pit_enable_out,
    input logic                 msg_valid,
    input logic [31:0]          msg_addr,
    input logic [31:0]          msg_data
);
    localparam logic [NUM_LINES-1:0] PASS_MASK =
        (NUM_LINES'(1) << tirq_pkg::LEG_LINE_A) | (NUM_LINES'(1) << tirq_pkg::LEG_LINE_B);

    // A stalled message keeps valid, address and data.
    p_msg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

    // Legacy timer run-enable follows the inverse of the previous mode.
    p_pit_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> pit_enable_out == !$past(legacy_mode));

    // With global enable off, only pass-through lines may be high.
    p_glb_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |-> (irq_line & ~PASS_MASK) == '0);

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
        // A clear write without a fire leaves the bit at zero.
        p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
            sts_wr && sts_wdata[i] && !fire[i] |=> !status[i]);

        // Level fire records the event; edge fire does not.
        p_level_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
            fire[i] && tmr_level[i] |=> status[i]);

        p_edge_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
            fire[i] && !tmr_level[i] |=> !status[i]);
    end
endmodule

bind tirq_router tirq_router_chk #(.NUM_TMR(NUM_TMR), .NUM_LINES(NUM_LINES)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .fire           (fire),
    .tmr_level      (tmr_level),
    .glb_en         (glb_en),
    .legacy_mode    (legacy_mode),
    .sts_wr         (sts_wr),
    .sts_wdata      (sts_wdata),
    .msg_ready      (msg_ready),
    .irq_line       (irq_line),
    .status         (status),
    .pit_enable_out (pit_enable_out),
    .msg_valid      (msg_valid),
    .msg_addr       (msg_addr),
    .msg_data       (msg_data)
);

// File: tb/tirq_router_tb.sv
`timescale 1ns/1ps
module tirq_router_tb;
    localparam int NT = 4;
    localparam int NL = 16;
    localparam int RW = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic            rst_n = 1'b0;
    logic [NT-1:0]   fire = '0, t_en = '0, t_lvl = '0, t_msg = '0;
    logic [NT*RW-1:0] route_flat;
    logic [NT*64-1:0] word_flat;
    logic            glb_en = 0, legacy = 0, sts_wr = 0, pit_in = 0, rtc_in = 0, msg_ready = 0;
    logic [NT-1:0]   sts_wdata = '0;
    logic [NL-1:0]   irq_line;
    logic [NT-1:0]   status;
    logic            pit_en, msg_valid;
    logic [31:0]     msg_addr, msg_data;

    int          t_route [NT];
    logic [63:0] t_word  [NT];

    always_comb begin
        for (int i = 0; i < NT; i++) begin
            route_flat[i*RW +: RW] = RW'(t_route[i]);
            word_flat[i*64 +: 64]  = t_word[i];
        end
    end

    tirq_router #(.NUM_TMR(NT), .NUM_LINES(NL)) u_dut (
        .clk(clk), .rst_n(rst_n), .fire(fire), .tmr_en(t_en), .tmr_level(t_lvl),
        .tmr_msg_en(t_msg), .tmr_route(route_flat), .tmr_msg_word(word_flat),
        .glb_en(glb_en), .legacy_mode(legacy), .sts_wr(sts_wr), .sts_wdata(sts_wdata),
        .pit_in(pit_in), .rtc_in(rtc_in), .msg_ready(msg_ready),
        .irq_line(irq_line), .status(status), .pit_enable_out(pit_en),
        .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data)
    );

    int    checks = 0;
    int    errors = 0;
    string tag = "R12";

    // Behavioural reference state.
    bit          m_sts [NT];
    bit          m_edge [NT];
    bit          m_pit, m_rtc, m_pen;
    int          m_queue [$];
    bit          m_v;
    logic [63:0] m_word;

    function automatic logic [NL-1:0] exp_lines();
        logic [NL-1:0] e = '0;
        for (int i = 0; i < NT; i++) begin
            int  d = t_route[i];
            bit  on;
            if (legacy && i == 0) d = 0;
            if (legacy && i == 1) d = 8;
            on = t_en[i] && glb_en && !t_msg[i] && (t_lvl[i] ? m_sts[i] : m_edge[i]);
            if (on) e[d] = 1'b1;
        end
        if (!legacy) begin
            e[0] = e[0] | m_pit;
            e[8] = e[8] | m_rtc;
        end
        return e;
    endfunction

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Model update on each rising edge from the inputs held since the last fall.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NT; i++) begin m_sts[i] = 0; m_edge[i] = 0; end
            m_pit = 0; m_rtc = 0; m_pen = 1; m_v = 0; m_word = '0;
            m_queue.delete();
        end else begin
            for (int i = 0; i < NT; i++) begin
                if (fire[i] && t_msg[i] && t_en[i] && glb_en) m_queue.push_back(i);
                if (fire[i]) m_sts[i] = t_lvl[i];
                else if (!t_lvl[i] || (sts_wr && sts_wdata[i])) m_sts[i] = 0;
                m_edge[i] = fire[i] && !t_lvl[i];
            end
            m_queue.sort();
            if (!m_v || msg_ready) begin
                m_v = (m_queue.size() > 0);
                if (m_v) m_word = t_word[m_queue.pop_front()];
            end
            m_pit = pit_in; m_rtc = rtc_in; m_pen = !legacy;
        end
    end

    // Full comparison against the model, settled before every rising edge.
    always @(negedge clk) begin
        #2;
        chk(irq_line, exp_lines(), tag, "irq_line");
        chk(status, {m_sts[3], m_sts[2], m_sts[1], m_sts[0]}, tag, "status");
        chk(pit_en, m_pen, tag, "pit_enable_out");
        chk(msg_valid, m_v, tag, "msg_valid");
        if (m_v) chk({msg_addr, msg_data}, m_word, tag, "message word");
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_fire(input logic [NT-1:0] m);
        fire = m;
        @(negedge clk);
        fire = '0;
    endtask

    task automatic w1c(input logic [NT-1:0] m, input logic [NT-1:0] f);
        sts_wr = 1; sts_wdata = m; fire = f;
        @(negedge clk);
        sts_wr = 0; sts_wdata = '0; fire = '0;
    endtask

    initial begin
        for (int i = 0; i < NT; i++) begin t_route[i] = 15; t_word[i] = '0; end
        step(4);
        rst_n = 1;
        // R12: idle state after reset.
        step(1);
        chk(status, '0, "R12", "status after reset");
        chk(irq_line, '0, "R12", "lines after reset");
        chk(msg_valid, 0, "R12", "msg_valid after reset");
        chk(pit_en, 1, "R12", "pit enable after reset");

        // R9 pass-through, R8 enable output, R9 remembered RTC level.
        tag = "R9";
        pit_in = 1; step(1); chk(irq_line[0], 1, "R9", "pit pass-through");
        rtc_in = 1; step(1); chk(irq_line[8], 1, "R9", "rtc pass-through");
        tag = "R8";
        legacy = 1; step(1);
        chk(pit_en, 0, "R8", "pit enable in legacy");
        chk(irq_line[0], 0, "R9", "pit blocked in legacy");
        chk(irq_line[8], 0, "R9", "rtc blocked in legacy");
        rtc_in = 0; step(2); rtc_in = 1; step(2);
        legacy = 0; step(1);
        chk(irq_line[8], 1, "R9", "rtc level restored on exit");
        chk(pit_en, 1, "R8", "pit enable after exit");
        pit_in = 0; rtc_in = 0; step(2);

        // R2 / R3 / R7 / R5 on a level timer routed to line 5.
        tag = "R3";
        glb_en = 1; t_lvl[2] = 1; t_route[2] = 5; t_en[2] = 0;
        pulse_fire(4'b0100);
        chk(status[2], 1, "R2", "level fire sets status while disabled");
        chk(irq_line[5], 0, "R3", "no delivery while disabled");
        t_en[2] = 1; step(1);
        chk(irq_line[5], 1, "R3", "enable asserts pending level");
        tag = "R7";
        glb_en = 0; step(1);
        chk(irq_line[5], 0, "R7", "global off lowers line");
        chk(status[2], 1, "R7", "global off keeps status");
        glb_en = 1; step(1);
        chk(irq_line[5], 1, "R3", "global on re-asserts");
        tag = "R5";
        w1c(4'b0000, '0);
        chk(status[2], 1, "R5", "zero write keeps status");
        w1c(4'b0100, '0);
        chk(status[2], 0, "R5", "one write clears status");
        chk(irq_line[5], 0, "R5", "one write lowers line");
        w1c(4'b0100, 4'b0100);
        chk(status[2], 1, "R5", "fire beats clear");

        // R6: switching to edge type clears pending level.
        tag = "R6";
        t_lvl[2] = 0; step(1);
        chk(status[2], 0, "R6", "edge type clears status");
        chk(irq_line[5], 0, "R6", "edge type lowers line");

        // R4: edge pulse on line 7.
        tag = "R4";
        t_lvl[3] = 0; t_en[3] = 1; t_route[3] = 7;
        pulse_fire(4'b1000);
        chk(irq_line[7], 1, "R4", "edge pulse present");
        chk(status[3], 0, "R2", "edge fire leaves status clear");
        step(1);
        chk(irq_line[7], 0, "R4", "edge pulse one cycle");

        // R1: legacy override for timers 0 and 1.
        tag = "R1";
        legacy = 1; t_en[1:0] = 2'b11; t_lvl[1:0] = 2'b11; t_route[0] = 3; t_route[1] = 4;
        pulse_fire(4'b0011);
        chk(irq_line[0], 1, "R1", "timer 0 on line 0");
        chk(irq_line[8], 1, "R1", "timer 1 on line 8");
        chk(irq_line[3], 0, "R1", "route field ignored in legacy");
        legacy = 0; step(1);
        chk(irq_line[3], 1, "R1", "timer 0 on its route");
        chk(irq_line[4], 1, "R1", "timer 1 on its route");
        w1c(4'b0011, '0); step(1);

        // R10 / R11: three simultaneous message fires with a stalled sink.
        tag = "R11";
        t_msg[2:0] = 3'b111; t_en[2:0] = 3'b111; t_lvl[2:0] = 3'b000;
        t_word[0] = 64'hA000_0000_0000_0011;
        t_word[1] = 64'hA000_0004_0000_0022;
        t_word[2] = 64'hA000_0008_0000_0033;
        pulse_fire(4'b0111);
        chk(msg_valid, 1, "R10", "request raised");
        chk(msg_addr, 32'hA000_0000, "R10", "address from upper half");
        chk(msg_data, 32'h0000_0011, "R10", "data from lower half");
        chk(irq_line, '0, "R10", "message drives no line");
        step(3);
        chk({msg_addr, msg_data}, t_word[0], "R11", "held while stalled");
        msg_ready = 1; step(1);
        chk({msg_addr, msg_data}, t_word[1], "R11", "second in order");
        step(1);
        chk({msg_addr, msg_data}, t_word[2], "R11", "third in order");
        step(1);
        chk(msg_valid, 0, "R11", "queue drained");
        msg_ready = 0; step(3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule